// File: doc/BRIEF.md
# Clock-Output Enable Register Slave on I2C

This block is an I2C slave that holds the enable bits for a clock generator's outputs. The register outputs drive the output gating of the clock tree directly: eight enables for the zero-delay buffer outputs, and seven for the processor, the two ASIC clocks and the four PCI clocks. A bus master reads and writes these enables over a two-wire standard-mode link at 100 kbit/s. SCL and SDA are sampled on a much faster system clock after two-flop synchronizers. The slave pulls SDA low through an output-enable pin on an open-drain line.

Transfers use a block protocol. After a write address, the master sends a command byte and a byte-count byte. The slave acknowledges both and discards them. Data bytes then fill the registers from index 0 upward. After a read address, the slave first returns a fixed byte count of 0x09 and then streams the registers in ascending order for as long as the master acknowledges. A repeated START begins address decoding again. A STOP, or a byte that the master does not acknowledge, ends the transfer.

Top module: `clk_ctrl_i2c_slave`

## Requirements
- R1: Only the 7-bit address 1101001 is acknowledged, which gives write byte 0xD2 and read byte 0xD3. Any other address byte gets no ACK, and the bytes that follow are ignored until the next START.
- R2: After 0xD2, the next two bytes are acknowledged and discarded. Each byte after them is acknowledged and written to register 0, then register 1, in that order. The registers change only on such data-byte writes.
- R3: After 0xD3, the slave sends 0x09 first, then register 0, then register 1, each MSB first. It moves to the next byte only after the master ACKs.
- R4: After reset, bufEn is 0xFF, coreEn is 0x7F and sdaOe is 0.
- R5: Register 1 maps bit 6 to the CPU enable, bits 5 and 4 to ASIC1 and ASIC0, and bits 3..0 to PCI3..PCI0. These appear as coreEn[6:0]. Its bit 7 always reads 0 and ignores writes. Register 0 bit n is bufEn[n].
- R6: Register indices 2 and above read 0xFF. Data written to them is acknowledged and discarded.
- R7: A master NACK after a read byte ends the transfer. The slave stops driving SDA until a new START.
- R8: A repeated START restarts address decoding, and the register index restarts at 0.
- R9: A STOP ends the transfer. Bytes clocked afterwards without a START get no ACK and write nothing.
- R10: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls the data line low |
| bufEn | output | 8 | Buffer output enables, bit n for output n |
| coreEn | output | 7 | CPU, ASIC1, ASIC0, PCI3..PCI0 enables |

## Verification
The bench drives the bus through an open-drain model with several patterns:
- A plain write followed by a read-back shows whether the two header bytes are really discarded and whether the byte count leads the read stream.
- A write that runs past the last register, and a read that runs past it, separate the 0xFF fill and the discarded data from wrap-around or aliasing.
- A foreign address, a write after STOP with no START, and a repeated START mid-write show whether decoding is tied to START alone.
- A read ended by NACK, followed by more clocks, shows whether the slave lets go of the line.

A bus monitor checks throughout that the slave starts pulling the line low only while SCL is low.

// File: rtl/clk_ctrl_i2c_pkg.sv
package clk_ctrl_i2c_pkg;

  localparam int NUM_REGS = 2;
  localparam int IDX_W = 3;
  localparam logic [6:0] DEFAULT_ADDR = 7'b1101001;
  localparam logic [7:0] BYTE_COUNT = 8'h09;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } busState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // capture rxBit into the shift register
    logic rxBit;      // synchronized data line
    logic loadTx;     // load the next byte to transmit
    logic loadCount;  // with loadTx: load the byte count instead of a register
    logic shiftOut;   // advance the transmit shift register
    logic writeReg;   // commit the received byte to the indexed register
    logic clrIdx;     // restart the register index at 0
  } dpStrobe_t;

  // writable bits per register; all writable bits reset to 1
  function automatic logic [7:0] regMask(input int idx);
    return (idx == 1) ? 8'h7F : 8'hFF;
  endfunction

endpackage

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import clk_ctrl_i2c_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int IW = IDX_W,
  parameter logic [7:0] COUNT_VAL = BYTE_COUNT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [NREG*8-1:0] regFlat
);

  localparam logic [IW-1:0] IDX_MAX = '1;

  logic [7:0]    shiftReg;
  logic [IW-1:0] regIdx;
  logic [7:0]    rdByte;

  assign rxByte = shiftReg;
  assign txBit  = shiftReg[7];

  // register bank, one block per register
  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= regMask(g);
      else if (strb.writeReg && regIdx == IW'(g)) q <= shiftReg & regMask(g);
    end
    assign regFlat[g*8 +: 8] = q;
  end

  // readback select; indices past the bank read all ones
  always_comb begin
    rdByte = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (regIdx == IW'(i)) rdByte = regFlat[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= 8'hFF;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[6:0], strb.rxBit};
    end else if (strb.loadTx) begin
      shiftReg <= strb.loadCount ? COUNT_VAL : rdByte;
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regIdx <= '0;
    else if (strb.clrIdx) regIdx <= '0;
    else if ((strb.writeReg || (strb.loadTx && !strb.loadCount)) && regIdx != IDX_MAX)
      regIdx <= regIdx + 1'b1;
  end

  // registers move only on a committed data byte
  assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeReg |=> $stable(regFlat));

  // index only grows between restarts, so stale indices never alias low registers
  assert_idx_monotonic_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrIdx |=> regIdx >= $past(regIdx));

endmodule

// File: rtl/i2c_bus_ctrl.sv
module i2c_bus_ctrl
  import clk_ctrl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEFAULT_ADDR
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strb,
  output logic       sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclS, sdaS, sclD, sdaD;
  logic       startDet, stopDet, sclRise, sclFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;

  busState_t  state;
  logic [3:0] bitCnt;
  logic       isAddr, isRead, mAck, ackDrive;
  logic [1:0] phase;  // write header progress: 0 command, 1 count, 2 data
  logic       matchAddr, byteDone;

  assign matchAddr = (rxByte[7:1] == DEV_ADDR);
  assign byteDone  = sclFall && (bitCnt == 4'd8);

  always_comb begin
    strb       = '0;
    strb.rxBit = sdaS;
    case (state)
      ST_RX: begin
        strb.shiftIn  = sclRise && (bitCnt < 4'd8);
        strb.writeReg = byteDone && !isAddr && (phase == 2'd2);
      end
      ST_RX_ACK: begin
        if (sclFall && isAddr) begin
          strb.clrIdx    = 1'b1;
          strb.loadTx    = isRead;
          strb.loadCount = isRead;
        end
      end
      ST_TX:     strb.shiftOut = sclFall && (bitCnt != 4'd0) && (bitCnt != 4'd8);
      ST_TX_ACK: strb.loadTx   = sclFall && mAck;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      isAddr   <= 1'b0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
      ackDrive <= 1'b0;
      phase    <= '0;
    end else if (startDet) begin
      state    <= ST_RX;
      bitCnt   <= '0;
      isAddr   <= 1'b1;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            bitCnt <= '0;
            if (isAddr && !matchAddr) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_RX_ACK;
              ackDrive <= 1'b1;
              if (isAddr) isRead <= rxByte[0];
              else if (phase != 2'd2) phase <= phase + 2'd1;
            end
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            isAddr   <= 1'b0;
            state    <= (isAddr && isRead) ? ST_TX : ST_RX;
            if (isAddr) phase <= '0;
          end
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            bitCnt <= '0;
            state  <= ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) mAck <= ~sdaS;
          if (sclFall) state <= mAck ? ST_TX : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = ackDrive | ((state == ST_TX) & ~txBit);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclS));

  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && isAddr && byteDone && !matchAddr && !startDet && !stopDet)
      |=> (state == ST_IDLE && !sdaOe));

  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX_ACK && sclFall && !mAck && !startDet && !stopDet)
      |=> (state == ST_IDLE && !sdaOe));

  assert_ack_not_in_tx_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && (state == ST_TX || state == ST_TX_ACK)));

endmodule

// File: rtl/clk_ctrl_i2c_slave.sv
module clk_ctrl_i2c_slave
  import clk_ctrl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEFAULT_ADDR
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [7:0] bufEn,
  output logic [6:0] coreEn
);

  dpStrobe_t           strb;
  logic [7:0]          rxByte;
  logic                txBit;
  logic [NUM_REGS*8-1:0] regFlat;
  logic                unusedBit;

  i2c_bus_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rxByte(rxByte),
    .txBit (txBit),
    .strb  (strb),
    .sdaOe (sdaOe)
  );

  i2c_reg_datapath #(.NREG(NUM_REGS), .IW(IDX_W), .COUNT_VAL(BYTE_COUNT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rxByte (rxByte),
    .txBit  (txBit),
    .regFlat(regFlat)
  );

  assign bufEn     = regFlat[7:0];
  assign coreEn    = regFlat[14:8];
  assign unusedBit = regFlat[15];

endmodule

// File: tb/clk_ctrl_i2c_slave_bench.sv
module clk_ctrl_i2c_slave_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaOe;
  logic [7:0] bufEn;
  logic [6:0] coreEn;

  int errors = 0;
  int checks = 0;
  int oeViol = 0;
  logic prevOe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  clk_ctrl_i2c_slave u_clk_ctrl_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .bufEn(bufEn), .coreEn(coreEn)
  );

  // R10 bus monitor: a new pull-down must start while SCL is low
  always @(negedge clk) begin
    if (rstN && sdaOe && !prevOe && sclM) oeViol++;
    prevOe <= sdaOe;
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitC(10);
    sdaM = 1'b0; waitC(10);
    sclM = 1'b0; waitC(10);
  endtask

  task automatic busRestart();
    sdaM = 1'b1; waitC(10);
    sclM = 1'b1; waitC(10);
    sdaM = 1'b0; waitC(10);
    sclM = 1'b0; waitC(10);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitC(10);
    sclM = 1'b1; waitC(10);
    sdaM = 1'b1; waitC(10);
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitC(10);
    sclM = 1'b1; waitC(20);
    sclM = 1'b0; waitC(10);
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitC(10);
    sclM = 1'b1; waitC(10);
    b = sdaLine; waitC(10);
    sclM = 1'b0; waitC(10);
  endtask

  task automatic putByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic getByte(input logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~giveAck);
  endtask

  task automatic testReset();
    chk("R4 bufEn", bufEn, 8'hFF);
    chk("R4 coreEn", {1'b0, coreEn}, 8'h7F);
    chk("R4 sdaOe", {7'd0, sdaOe}, 8'h00);
  endtask

  task automatic testWrite();
    logic a;
    busStart();
    putByte(8'hD2, a); chk("R1 write address ack", {7'd0, a}, 8'h01);
    putByte(8'h55, a); chk("R2 command ack", {7'd0, a}, 8'h01);
    putByte(8'h33, a); chk("R2 count ack", {7'd0, a}, 8'h01);
    chk("R2 header discarded", bufEn, 8'hFF);
    putByte(8'hA5, a); chk("R2 data0 ack", {7'd0, a}, 8'h01);
    putByte(8'hC3, a); chk("R2 data1 ack", {7'd0, a}, 8'h01);
    busStop();
    chk("R2 reg0 written", bufEn, 8'hA5);
    chk("R5 reg1 bit7 dropped", {1'b0, coreEn}, 8'h43);
  endtask

  task automatic testRead();
    logic a;
    logic [7:0] v;
    busStart();
    putByte(8'hD3, a); chk("R1 read address ack", {7'd0, a}, 8'h01);
    getByte(1'b1, v); chk("R3 byte count first", v, 8'h09);
    getByte(1'b1, v); chk("R3 reg0 readback", v, 8'hA5);
    getByte(1'b1, v); chk("R5 reg1 readback bit7 zero", v, 8'h43);
    getByte(1'b0, v); chk("R6 past bank reads ones", v, 8'hFF);
    busStop();
  endtask

  task automatic testForeign();
    logic a;
    busStart();
    putByte(8'hA4, a); chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    putByte(8'h00, a); chk("R1 ignored byte nack", {7'd0, a}, 8'h00);
    putByte(8'h00, a);
    busStop();
    chk("R1 reg0 untouched", bufEn, 8'hA5);
    chk("R1 reg1 untouched", {1'b0, coreEn}, 8'h43);
  endtask

  task automatic testBeyond();
    logic a;
    logic [7:0] v;
    busStart();
    putByte(8'hD2, a); putByte(8'h00, a); putByte(8'h00, a);
    putByte(8'h11, a); putByte(8'h22, a);
    putByte(8'h33, a); chk("R6 extra byte acked", {7'd0, a}, 8'h01);
    busStop();
    chk("R6 reg0", bufEn, 8'h11);
    chk("R6 reg1", {1'b0, coreEn}, 8'h22);
    busStart();
    putByte(8'hD3, a);
    getByte(1'b1, v); chk("R3 count again", v, 8'h09);
    getByte(1'b1, v); chk("R3 reg0", v, 8'h11);
    getByte(1'b1, v); chk("R3 reg1", v, 8'h22);
    getByte(1'b1, v); chk("R6 extra write discarded", v, 8'hFF);
    getByte(1'b0, v); chk("R6 still ones", v, 8'hFF);
    busStop();
  endtask

  task automatic testRestart();
    logic a;
    logic [7:0] v;
    busStart();
    putByte(8'hD2, a); putByte(8'h00, a); putByte(8'h00, a);
    putByte(8'h01, a);
    chk("R8 first write", bufEn, 8'h01);
    busRestart();
    putByte(8'hD2, a); chk("R8 re-address ack", {7'd0, a}, 8'h01);
    putByte(8'h7E, a); putByte(8'h7D, a);
    chk("R8 header after restart ignored", bufEn, 8'h01);
    putByte(8'h0F, a); putByte(8'h0E, a);
    chk("R8 index back to reg0", bufEn, 8'h0F);
    chk("R8 reg1", {1'b0, coreEn}, 8'h0E);
    busRestart();
    putByte(8'hD3, a); chk("R8 read after restart ack", {7'd0, a}, 8'h01);
    getByte(1'b1, v); chk("R8 count", v, 8'h09);
    getByte(1'b1, v); chk("R8 reg0", v, 8'h0F);
    getByte(1'b0, v); chk("R8 reg1", v, 8'h0E);
    busStop();
  endtask

  task automatic testNack();
    logic a;
    logic [7:0] v;
    int oeSeen;
    busStart();
    putByte(8'hD3, a);
    getByte(1'b0, v); chk("R7 count before nack", v, 8'h09);
    oeSeen = 0;
    for (int k = 0; k < 9; k++) begin
      sdaM = 1'b1; waitC(10);
      sclM = 1'b1; if (sdaOe) oeSeen++; waitC(10);
      if (sdaOe) oeSeen++;
      waitC(10);
      sclM = 1'b0; waitC(10);
      if (sdaOe) oeSeen++;
    end
    chk("R7 released after nack", oeSeen[7:0], 8'h00);
    busStop();
  endtask

  task automatic testStopEnds();
    logic a;
    logic b;
    busStart();
    putByte(8'hD2, a); putByte(8'h00, a); putByte(8'h00, a);
    busStop();
    sclM = 1'b0; waitC(10);
    for (int i = 7; i >= 0; i--) putBit(1'b0);
    getBit(b);
    chk("R9 no ack after stop", {7'd0, ~b}, 8'h00);
    for (int i = 7; i >= 0; i--) putBit(1'b1);
    getBit(b);
    sclM = 1'b1; waitC(10);
    sdaM = 1'b1; waitC(10);
    chk("R9 reg0 unchanged", bufEn, 8'h0F);
    chk("R9 reg1 unchanged", {1'b0, coreEn}, 8'h0E);
  endtask

  initial begin
    waitC(5);
    rstN = 1'b1;
    waitC(5);
    testReset();
    testWrite();
    testRead();
    testForeign();
    testBeyond();
    testRestart();
    testNack();
    testStopEnds();
    chk("R10 pull-down starts with SCL low", oeViol[7:0], 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule